// File: doc/BRIEF.md
# SPI Command-Buffer Transfer Engine

This block is an SPI master sequencer that takes its work from a shared 512-byte buffer. Software fills the buffer through a byte-wide host port. It writes a 16-bit command header at the bottom of the buffer and the outgoing bytes directly after it. Software then pulses a start command. The start command names one of eight slave selects, one of eight timing profiles, and a prepend count.

When a start is accepted, the engine reads the header and frames one transaction with the chosen select held low. It shifts bytes MSB first in SPI mode 0. Received bytes are written back into the buffer from offset 0. At the end of the transaction the engine sets a done status bit, which can raise an interrupt when the mask allows it.

The serial bit rate comes from an external half-period tick. The engine outputs the selected profile index, so the clock generator can choose the rate that goes with it. The prepend count makes it possible to send a short command and then read the reply within a single select assertion.

Top module: `spi_cmdbuf_engine`

## Requirements
- R1: Host writes to the buffer take effect when the engine is idle. A host read returns the addressed byte on `hb_rdata` one clock after the request.
- R2: The header is little-endian: buffer byte 0 holds header bits 7:0 and byte 1 holds bits 15:8. Bits 15:13 are the opcode (0 sleep, 1 full-duplex, 2 write-only, 3 read-only) and bits 12:0 are the byte count, which can exceed 255.
- R3: Write-only sends exactly count bytes, taken from buffer offsets 2, 3, and onward. Each byte goes MSB first, with SCK idle low, data valid before the rising edge, and data changing after the falling edge.
- R4: Read-only first sends the prepend count of bytes from offset 2. It then clocks count further bytes with MOSI held at 0x00, and stores only those received bytes at offsets 0, 1, and onward.
- R5: Full-duplex sends count bytes from offset 2 upward. It stores the byte received in the same slot k at offset k.
- R6: Only the selected `ss_n` line goes low, and it stays low for the whole frame. It falls at least one tick interval before the first SCK rise. SCK stays low whenever no select is low.
- R7: A sleep opcode, or a transaction whose total byte count is zero, asserts no select and still completes with done status set.
- R8: `busy` is high from an accepted start until completion. While busy, further starts and host buffer writes are dropped.
- R9: Completion sets the done status. `irq` equals status AND mask. A clear pulse zeroes the status, but a completion in the same cycle wins.
- R10: `profile_sel` shows the profile index captured by the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hb_en | input | 1 | Host buffer access enable |
| hb_we | input | 1 | Host buffer write (with hb_en) |
| hb_addr | input | 9 | Host buffer byte address |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte, one cycle latency |
| cmd_start | input | 1 | Start pulse |
| cmd_ss | input | 3 | Slave-select index for the start |
| cmd_profile | input | 3 | Timing profile index for the start |
| cmd_prepend | input | 4 | Bytes sent before a read phase |
| half_tick | input | 1 | One pulse per SCK half period |
| irq_mask_we | input | 1 | Write strobe for the done mask |
| irq_mask_wdata | input | 1 | New done mask value |
| irq_clear | input | 1 | Clear-all pulse for status |
| irq | output | 1 | Masked interrupt |
| done_status | output | 1 | Raw done status |
| busy | output | 1 | Transaction in progress |
| profile_sel | output | 3 | Active timing profile |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Active-low slave selects |

## Verification
The bench targets the prepend boundary: a read that sends two command bytes and then three zero bytes must store the reply at offsets 0 to 2. An off-by-prepend error would store the echo of the command bytes, or shift the reply by two. A count of 260 checks that the header's upper byte is decoded; a design that swaps the header bytes or keeps only the low byte would send 4 bytes or none. Zero-length and sleep commands must finish without a select pulse, so an engine that always frames would show an extra select fall. A start issued mid-transfer and a host write issued mid-transfer must leave the profile, the frame count and the buffer unchanged.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int HDR_W     = 16;
    localparam int OPC_W     = 3;
    localparam int HDR_LEN_W = HDR_W - OPC_W;
    localparam int TX_BASE   = 2;

    localparam logic [OPC_W-1:0] OP_SLEEP  = 3'd0;
    localparam logic [OPC_W-1:0] OP_DUPLEX = 3'd1;
    localparam logic [OPC_W-1:0] OP_WRITE  = 3'd2;
    localparam logic [OPC_W-1:0] OP_READ   = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/cmdbuf_ram.sv
module cmdbuf_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_en,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          eng_busy,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata,
    output logic [15:0]   eng_hdr,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata
);
    logic [7:0] mem [DEPTH];

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rdata_d, rdata_q;

    // Engine writes have priority; host writes are dropped while busy.
    always_comb begin
        wr_en   = eng_we | (host_en & host_we & ~eng_busy);
        wr_addr = eng_we ? eng_waddr : host_addr;
        wr_data = eng_we ? eng_wdata : host_wdata;
        rdata_d = (host_en & ~host_we) ? mem[host_addr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign host_rdata = rdata_q;
    assign eng_rdata  = mem[eng_raddr];
    assign eng_hdr    = {mem[1], mem[0]};

    a_r8_engine_write_only_when_busy: assert property (
        @(posedge clk) disable iff (!rst_n) eng_we |-> eng_busy);
endmodule

// File: rtl/done_irq_ctrl.sv
module done_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic mask_we,
    input  logic mask_wdata,
    input  logic clear,
    output logic status,
    output logic irq
);
    typedef struct packed {
        logic status;
        logic mask;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we) begin
            s_d.mask = mask_wdata;
        end
        if (clear) begin
            s_d.status = 1'b0;
        end
        if (done) begin
            s_d.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.status;
    assign irq    = s_q.status & s_q.mask;

    a_r9_done_sets_status: assert property (
        @(posedge clk) disable iff (!rst_n) done |=> status);
    a_r9_clear_zeroes: assert property (
        @(posedge clk) disable iff (!rst_n) (clear && !done) |=> !status);
    a_r9_irq_needs_status: assert property (
        @(posedge clk) disable iff (!rst_n) irq |-> status);
endmodule

// File: rtl/spi_seq.sv
module spi_seq
    import spi_cmd_pkg::*;
#(
    parameter int AW    = 9,
    parameter int NSS   = 8,
    parameter int NPROF = 8,
    parameter int PRE_W = 4,
    parameter int SSW   = $clog2(NSS),
    parameter int PFW   = $clog2(NPROF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SSW-1:0]   start_ss,
    input  logic [PFW-1:0]   start_prof,
    input  logic [PRE_W-1:0] start_pre,
    input  logic             tick,
    input  logic [15:0]      hdr,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic [NSS-1:0]   ss_n,
    output logic             busy,
    output logic [PFW-1:0]   profile,
    output logic             done
);
    localparam int IW = HDR_LEN_W + 1;

    typedef struct packed {
        seq_state_e       st;
        logic [OPC_W-1:0] op;
        logic [PRE_W-1:0] pre;
        logic [IW-1:0]    total;
        logic [IW-1:0]    idx;
        logic [2:0]       bitc;
        logic             sck;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic [SSW-1:0]   ss;
        logic [PFW-1:0]   prof;
    } seq_t;

    seq_t q, n;

    logic [IW-1:0]        nxt_idx, rd_idx, total_v;
    logic [OPC_W-1:0]     hdr_op;
    logic [HDR_LEN_W-1:0] hdr_len;
    logic                 zero_tx;
    logic [7:0]           fetch;

    always_comb begin
        hdr_op  = hdr[HDR_W-1 -: OPC_W];
        hdr_len = hdr[HDR_LEN_W-1:0];
        case (hdr_op)
            OP_READ:            total_v = IW'(start_pre) + IW'(hdr_len);
            OP_WRITE, OP_DUPLEX: total_v = IW'(hdr_len);
            default:            total_v = '0;
        endcase

        nxt_idx = q.idx + IW'(1);
        rd_idx  = (q.st == ST_SHIFT) ? nxt_idx : q.idx;
        rd_addr = AW'(rd_idx + IW'(TX_BASE));
        zero_tx = (q.op == OP_READ) && (rd_idx >= IW'(q.pre));
        fetch   = zero_tx ? 8'h00 : rd_data;

        n       = q;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = q.rx;
        done    = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.op   = hdr_op;
                    n.pre  = start_pre;
                    n.total = total_v;
                    n.idx  = '0;
                    n.bitc = '0;
                    n.sck  = 1'b0;
                    n.ss   = start_ss;
                    n.prof = start_prof;
                    n.st   = (total_v == '0) ? ST_FINISH : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    n.tx = fetch;
                    n.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sck) begin
                        n.sck = 1'b1;
                        n.rx  = {q.rx[6:0], miso};
                    end else begin
                        n.sck = 1'b0;
                        if (q.bitc == 3'd7) begin
                            if (q.op == OP_DUPLEX) begin
                                wr_en   = 1'b1;
                                wr_addr = AW'(q.idx);
                            end else if (q.op == OP_READ && q.idx >= IW'(q.pre)) begin
                                wr_en   = 1'b1;
                                wr_addr = AW'(q.idx - IW'(q.pre));
                            end
                            n.idx = nxt_idx;
                            if (nxt_idx == q.total) begin
                                n.st = ST_TRAIL;
                            end else begin
                                n.tx   = fetch;
                                n.bitc = '0;
                            end
                        end else begin
                            n.tx   = {q.tx[6:0], 1'b0};
                            n.bitc = q.bitc + 3'd1;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    n.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                done = 1'b1;
                n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    logic framing;
    assign framing = (q.st == ST_LEAD) || (q.st == ST_SHIFT) || (q.st == ST_TRAIL);
    assign ss_n    = framing ? ~(NSS'(1) << q.ss) : '1;
    assign sck     = q.sck;
    assign mosi    = (q.st == ST_SHIFT) ? q.tx[7] : 1'b0;
    assign busy    = (q.st != ST_IDLE);
    assign profile = q.prof;

    a_r6_sck_idle_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) (&ss_n) |-> !sck);
    a_r6_single_select: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(~ss_n));
    a_r8_start_ignored_busy: assert property (
        @(posedge clk) disable iff (!rst_n) (busy && start) |=> (profile == $past(profile)));
    a_r7_empty_no_select: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!busy && start && total_v == '0) |=> ((&ss_n) && busy));
endmodule

// File: rtl/spi_cmdbuf_engine.sv
module spi_cmdbuf_engine #(
    parameter int BUF_BYTES = 512,
    parameter int NSS       = 8,
    parameter int NPROF     = 8,
    parameter int PRE_W     = 4,
    parameter int AW        = $clog2(BUF_BYTES),
    parameter int SSW       = $clog2(NSS),
    parameter int PFW       = $clog2(NPROF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_en,
    input  logic             hb_we,
    input  logic [AW-1:0]    hb_addr,
    input  logic [7:0]       hb_wdata,
    output logic [7:0]       hb_rdata,
    input  logic             cmd_start,
    input  logic [SSW-1:0]   cmd_ss,
    input  logic [PFW-1:0]   cmd_profile,
    input  logic [PRE_W-1:0] cmd_prepend,
    input  logic             half_tick,
    input  logic             irq_mask_we,
    input  logic             irq_mask_wdata,
    input  logic             irq_clear,
    output logic             irq,
    output logic             done_status,
    output logic             busy,
    output logic [PFW-1:0]   profile_sel,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic [NSS-1:0]   ss_n
);
    logic [AW-1:0] eng_raddr, eng_waddr;
    logic [7:0]    eng_rdata, eng_wdata;
    logic [15:0]   eng_hdr;
    logic          eng_we, eng_done;

    cmdbuf_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_en   (hb_en),
        .host_we   (hb_we),
        .host_addr (hb_addr),
        .host_wdata(hb_wdata),
        .host_rdata(hb_rdata),
        .eng_busy  (busy),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata),
        .eng_hdr   (eng_hdr),
        .eng_we    (eng_we),
        .eng_waddr (eng_waddr),
        .eng_wdata (eng_wdata)
    );

    spi_seq #(.AW(AW), .NSS(NSS), .NPROF(NPROF), .PRE_W(PRE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .start_ss  (cmd_ss),
        .start_prof(cmd_profile),
        .start_pre (cmd_prepend),
        .tick      (half_tick),
        .hdr       (eng_hdr),
        .rd_addr   (eng_raddr),
        .rd_data   (eng_rdata),
        .wr_en     (eng_we),
        .wr_addr   (eng_waddr),
        .wr_data   (eng_wdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .ss_n      (ss_n),
        .busy      (busy),
        .profile   (profile_sel),
        .done      (eng_done)
    );

    done_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (eng_done),
        .mask_we   (irq_mask_we),
        .mask_wdata(irq_mask_wdata),
        .clear     (irq_clear),
        .status    (done_status),
        .irq       (irq)
    );
endmodule

// File: tb/spi_cmdbuf_engine_test.sv
module spi_cmdbuf_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;

    logic clk = 0, rst_n = 0;
    logic hb_en = 0, hb_we = 0;
    logic [8:0] hb_addr = '0;
    logic [7:0] hb_wdata = '0, hb_rdata;
    logic cmd_start = 0;
    logic [2:0] cmd_ss = '0, cmd_profile = '0;
    logic [3:0] cmd_prepend = '0;
    logic half_tick = 0;
    logic irq_mask_we = 0, irq_mask_wdata = 0, irq_clear = 0;
    logic irq, done_status, busy, sck, mosi, miso;
    logic [2:0] profile_sel;
    logic [7:0] ss_n;

    int errors = 0, checks = 0;

    spi_cmdbuf_engine uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt  = (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
        half_tick = (tick_cnt == 0);
    end

    // Slave model
    function automatic logic [7:0] pat(int j);
        return 8'((j * 37) + 90);
    endfunction

    logic ss_any;
    assign ss_any = &ss_n;
    logic [7:0] s_tx = '0, s_rx = '0;
    logic [7:0] cap [64];
    int s_bits = 0, frame_bytes = 0, ss_falls = 0, last_ss = -1;
    time ss_fall_t = 0;
    int setup_bad = 0;
    assign miso = s_tx[7];

    always @(negedge ss_any) begin
        frame_bytes = 0; s_bits = 0; s_tx = pat(0);
        ss_falls++; ss_fall_t = $time;
        for (int i = 0; i < 8; i++) if (!ss_n[i]) last_ss = i;
    end
    always @(posedge sck) begin
        if (s_bits == 0 && frame_bytes == 0 && ($time - ss_fall_t) < TICK_DIV*CLK_PERIOD)
            setup_bad++;
        s_rx = {s_rx[6:0], mosi};
        s_bits++;
        if (s_bits == 8) begin
            if (frame_bytes < 64) cap[frame_bytes] = s_rx;
            frame_bytes++;
            s_bits = 0;
        end
    end
    always @(negedge sck) begin
        if (s_bits == 0) s_tx = pat(frame_bytes);
        else             s_tx = {s_tx[6:0], 1'b0};
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        hb_en = 1; hb_we = 1; hb_addr = 9'(a); hb_wdata = d;
        @(negedge clk);
        hb_en = 0; hb_we = 0;
    endtask

    task automatic host_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        hb_en = 1; hb_we = 0; hb_addr = 9'(a);
        @(negedge clk);
        hb_en = 0;
        d = hb_rdata;
    endtask

    task automatic start_cmd(input int ss, input int prof, input int pre);
        @(negedge clk);
        cmd_start = 1; cmd_ss = 3'(ss); cmd_profile = 3'(prof); cmd_prepend = 4'(pre);
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 60000) begin @(negedge clk); n++; end
        check(!busy, "R8 busy release", busy, 0);
    endtask

    task automatic set_mask(input logic m);
        @(negedge clk); irq_mask_we = 1; irq_mask_wdata = m;
        @(negedge clk); irq_mask_we = 0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clear = 1;
        @(negedge clk); irq_clear = 0;
    endtask

    task automatic t_reset();
        check(!busy, "R8 reset busy", busy, 0);
        check(ss_n == 8'hFF, "R6 reset ss_n", ss_n, 8'hFF);
        check(!sck, "R6 reset sck", sck, 0);
        check(!irq && !done_status, "R9 reset irq", {irq, done_status}, 0);
    endtask

    task automatic t_write();
        int f0 = ss_falls;
        host_wr(0, 8'h03); host_wr(1, 8'h40);
        host_wr(2, 8'hA1); host_wr(3, 8'hB2); host_wr(4, 8'hC3);
        set_mask(1);
        start_cmd(5, 6, 0);
        check(busy, "R8 busy after start", busy, 1);
        check(profile_sel == 3'd6, "R10 profile", profile_sel, 6);
        wait_idle();
        check(frame_bytes == 3, "R3 write byte count", frame_bytes, 3);
        check(cap[0] == 8'hA1 && cap[1] == 8'hB2 && cap[2] == 8'hC3, "R3 write data",
              {cap[0], cap[1], cap[2]}, 24'hA1B2C3);
        check(last_ss == 5 && ss_falls == f0 + 1, "R6 select line", last_ss, 5);
        check(setup_bad == 0, "R6 select lead time", setup_bad, 0);
        check(done_status && irq, "R9 done irq", {done_status, irq}, 3);
        clear_irq();
        check(!done_status && !irq, "R9 clear", {done_status, irq}, 0);
    endtask

    task automatic t_read_prepend();
        logic [7:0] d;
        host_wr(0, 8'h03); host_wr(1, 8'h60);
        host_wr(2, 8'h9F); host_wr(3, 8'h05);
        start_cmd(2, 1, 2);
        wait_idle();
        check(frame_bytes == 5, "R4 frame length", frame_bytes, 5);
        check(cap[0] == 8'h9F && cap[1] == 8'h05, "R4 prepend bytes", {cap[0], cap[1]}, 16'h9F05);
        check(cap[2] == 0 && cap[3] == 0 && cap[4] == 0, "R4 zero fill",
              {cap[2], cap[3], cap[4]}, 0);
        for (int i = 0; i < 3; i++) begin
            host_rd(i, d);
            check(d == pat(i + 2), "R4 stored reply (R1 read)", d, pat(i + 2));
        end
        clear_irq();
    endtask

    task automatic t_duplex();
        logic [7:0] d;
        host_wr(0, 8'h02); host_wr(1, 8'h20);
        host_wr(2, 8'h5A); host_wr(3, 8'hC7);
        start_cmd(7, 3, 0);
        wait_idle();
        check(frame_bytes == 2 && cap[0] == 8'h5A && cap[1] == 8'hC7, "R5 duplex tx",
              {cap[0], cap[1]}, 16'h5AC7);
        host_rd(0, d); check(d == pat(0), "R5 rx slot 0", d, pat(0));
        host_rd(1, d); check(d == pat(1), "R5 rx slot 1", d, pat(1));
        clear_irq();
    endtask

    task automatic t_empty();
        int f0 = ss_falls;
        host_wr(0, 8'h00); host_wr(1, 8'h40);
        start_cmd(1, 0, 0);
        wait_idle();
        check(ss_falls == f0 && done_status, "R7 zero count", ss_falls - f0, 0);
        clear_irq();
        host_wr(0, 8'h05); host_wr(1, 8'h00);
        start_cmd(1, 0, 0);
        wait_idle();
        check(ss_falls == f0 && done_status, "R7 sleep opcode", ss_falls - f0, 0);
        clear_irq();
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        int f0;
        host_wr(300, 8'h11);
        set_mask(0);
        host_wr(0, 8'h04); host_wr(1, 8'h40);
        f0 = ss_falls;
        start_cmd(4, 5, 0);
        repeat (10) @(negedge clk);
        start_cmd(1, 2, 0);
        host_wr(300, 8'h77);
        check(profile_sel == 3'd5, "R8 late start ignored", profile_sel, 5);
        wait_idle();
        check(ss_falls == f0 + 1 && last_ss == 4, "R8 single frame", ss_falls - f0, 1);
        check(frame_bytes == 4, "R8 frame unchanged", frame_bytes, 4);
        host_rd(300, d);
        check(d == 8'h11, "R8 host write dropped", d, 8'h11);
        check(done_status && !irq, "R9 masked irq", {done_status, irq}, 2);
        clear_irq();
    endtask

    task automatic t_long_len();
        host_wr(0, 8'h04); host_wr(1, 8'h41);
        start_cmd(0, 0, 0);
        wait_idle();
        check(frame_bytes == 260, "R2 header high byte", frame_bytes, 260);
        clear_irq();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read_prepend();
        t_duplex();
        t_empty();
        t_busy_ignore();
        t_long_len();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule